// File: doc/BRIEF.md
# Serial ADC Result Receiver

This block starts conversions on an external 12-bit converter and collects the result that the converter sends back over a serial line. A sample request makes the block pull the active-low convert strobe down for a fixed number of system-clock cycles. The converter then drives its busy line low, supplies its own data clock and shifts out one word, most significant bit first. Busy goes high again once both the conversion and the serial transfer are over. The receiver brings the data clock, the data line and busy into the system clock domain through two-flop synchronisers. It takes one bit on each rising edge of the synchronised data clock and closes the frame when busy rises.

A frame always carries the result of the conversion before it, so every delivered word describes the previous sample. The first frame after reset carries no earlier sample and is marked stale. If busy rises after any count of bits other than exactly twelve, the frame is reported as a framing error and no result is delivered. A spacing counter keeps convert strobes far enough apart for the converter to acquire its input again. Requests that arrive during a frame, or while busy is low, are dropped.

Top module: `serial_adc_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `adc_conv_n` is high and `res_valid` and `res_frame_err` are low, with `res_data` at zero and `res_stale` low.
- R2: Each convert strobe keeps `adc_conv_n` low for exactly `CONV_LOW_CYC` system-clock cycles. Elaboration stops with an error if `CONV_LOW_CYC * CLK_PERIOD_PS` lies outside 40 000 ps to 12 000 000 ps.
- R3: A strobe starts only from idle while the synchronised busy line is high. A request held high during a frame, or while the converter holds busy low, produces no extra strobe.
- R4: Two falling edges of `adc_conv_n` are at least `CONV_GAP_CYC` cycles apart. With the request held high, the next strobe falls exactly `CONV_GAP_CYC` cycles after the previous one once the frame has ended.
- R5: Bits are taken on rising edges of the data clock. The first bit received lands in `res_data[11]` and the twelfth in `res_data[0]`, so the word read as signed two's complement keeps the value the converter sent.
- R6: When busy rises after exactly 12 data-clock rising edges, `res_valid` is high for exactly one cycle and `res_data` holds the received word.
- R7: When busy rises after any other count of rising edges (0, 11, 13 or more), `res_frame_err` is high for exactly one cycle, `res_valid` stays low and `res_data` keeps its previous value. `res_valid` and `res_frame_err` are never high together.
- R8: `res_stale` is 1 together with the word of the first frame that closes after reset, and 0 for every frame after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_req | input | 1 | Level request to start a conversion |
| adc_dclk | input | 1 | Data clock driven by the converter (asynchronous) |
| adc_sdata | input | 1 | Serial data from the converter, MSB first (asynchronous) |
| adc_busy_n | input | 1 | Converter busy, low during conversion and transfer (asynchronous) |
| adc_conv_n | output | 1 | Active-low convert strobe |
| res_data | output | 12 | Last good received word, two's complement |
| res_valid | output | 1 | One-cycle pulse when `res_data` is updated |
| res_stale | output | 1 | Marks the delivered word as the post-reset frame with no real sample |
| res_frame_err | output | 1 | One-cycle pulse when a frame closes with a wrong bit count |

## Verification
The conditions hardest to reach from the ports are a busy rise after a wrong bit count and a strobe that lands exactly on the spacing limit. A well-behaved converter never produces either. The bench models the converter itself and can emit any number of data-clock pulses per frame, including none, eleven and thirteen. It also holds the request high without a break, so every strobe after the first lands exactly on the spacing limit. A sweep of several hundred words covers every single-bit position, both sign extremes and a stride through the whole code space. Each word is compared with the signed value the bench computes.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_STROBE = 2'd1,
    RX_WAIT   = 2'd2,
    RX_RECV   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_shift.sv
module adc_shift #(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CNT_MAX = DATA_W + 1,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (bit_en) begin
      word_d = {word_q[DATA_W-2:0], bit_in};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr || bit_en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word  = word_q;
  assign count = cnt_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_rx_pkg::*;
#(
  parameter int unsigned CONV_LOW_CYC = 10,
  parameter int unsigned CONV_GAP_CYC = 6250,
  localparam int unsigned LOW_W = $clog2(CONV_LOW_CYC + 1),
  localparam int unsigned GAP_W = $clog2(CONV_GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy_n_s,
  input  logic busy_rise,
  output logic conv_n,
  output logic frame_clr,
  output logic capture_en,
  output logic frame_end
);
  rx_state_e  state_q, state_d;
  logic       conv_n_q, conv_n_d;
  logic [LOW_W-1:0] low_q, low_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    state_d    = state_q;
    conv_n_d   = conv_n_q;
    low_d      = low_q;
    gap_d      = (gap_q != '0) ? gap_q - 1'b1 : gap_q;
    frame_clr  = 1'b0;
    capture_en = 1'b0;
    frame_end  = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (req && busy_n_s && (gap_q == '0)) begin
          state_d   = RX_STROBE;
          conv_n_d  = 1'b0;
          low_d     = LOW_W'(CONV_LOW_CYC - 1);
          gap_d     = GAP_W'(CONV_GAP_CYC - 1);
          frame_clr = 1'b1;
        end
      end
      RX_STROBE: begin
        capture_en = 1'b1;
        if (low_q == '0) begin
          conv_n_d = 1'b1;
          state_d  = RX_WAIT;
        end else begin
          low_d = low_q - 1'b1;
        end
      end
      RX_WAIT: begin
        capture_en = 1'b1;
        if (!busy_n_s) state_d = RX_RECV;
      end
      RX_RECV: begin
        capture_en = 1'b1;
        if (busy_rise) begin
          frame_end = 1'b1;
          state_d   = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      conv_n_q <= 1'b1;
      low_q    <= '0;
      gap_q    <= '0;
    end else begin
      state_q  <= state_d;
      conv_n_q <= conv_n_d;
      low_q    <= low_d;
      gap_q    <= gap_d;
    end
  end

  assign conv_n = conv_n_q;
endmodule

// File: rtl/serial_adc_rx.sv
module serial_adc_rx #(
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned CONV_LOW_CYC  = 10,
  parameter int unsigned CONV_GAP_CYC  = 6250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_req,
  input  logic              adc_dclk,
  input  logic              adc_sdata,
  input  logic              adc_busy_n,
  output logic              adc_conv_n,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              res_stale,
  output logic              res_frame_err
);
  localparam longint unsigned LOW_PS  = longint'(CONV_LOW_CYC) * longint'(CLK_PERIOD_PS);
  localparam int unsigned     CNT_W   = $clog2(DATA_W + 2);

  // R2: strobe low time must stay inside the converter's allowed window
  generate
    if (LOW_PS < 64'd40000 || LOW_PS > 64'd12000000) begin : g_bad_low_time
      $error("convert strobe low time out of range");
    end
  endgenerate

  logic dclk_s, sdata_s, busy_s;
  logic dclk_q, busy_q;
  logic dclk_rise, busy_rise;
  logic frame_clr, capture_en, frame_end;
  logic [DATA_W-1:0] shift_word;
  logic [CNT_W-1:0]  shift_cnt;

  adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dclk (
    .clk(clk), .rst_n(rst_n), .d(adc_dclk), .q(dclk_s));
  adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdata (
    .clk(clk), .rst_n(rst_n), .d(adc_sdata), .q(sdata_s));
  adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_busy (
    .clk(clk), .rst_n(rst_n), .d(adc_busy_n), .q(busy_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      dclk_q <= dclk_s;
      busy_q <= busy_s;
    end
  end

  assign dclk_rise = dclk_s & ~dclk_q;
  assign busy_rise = busy_s & ~busy_q;

  adc_conv_ctrl #(
    .CONV_LOW_CYC(CONV_LOW_CYC),
    .CONV_GAP_CYC(CONV_GAP_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (sample_req),
    .busy_n_s  (busy_s),
    .busy_rise (busy_rise),
    .conv_n    (adc_conv_n),
    .frame_clr (frame_clr),
    .capture_en(capture_en),
    .frame_end (frame_end)
  );

  adc_shift #(.DATA_W(DATA_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_clr),
    .bit_en(capture_en & dclk_rise),
    .bit_in(sdata_s),
    .word  (shift_word),
    .count (shift_cnt)
  );

  logic              first_q, first_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              stale_q, stale_d;
  logic              err_q, err_d;
  logic              frame_ok;

  assign frame_ok = (shift_cnt == CNT_W'(DATA_W));

  always_comb begin
    first_d = first_q;
    data_d  = data_q;
    stale_d = stale_q;
    valid_d = 1'b0;
    err_d   = 1'b0;
    if (frame_end) begin
      first_d = 1'b0;
      if (frame_ok) begin
        valid_d = 1'b1;
        data_d  = shift_word;
        stale_d = first_q;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      data_q  <= '0;
      stale_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (frame_end) begin
        first_q <= first_d;
        data_q  <= data_d;
        stale_q <= stale_d;
      end
    end
  end

  assign res_data      = data_q;
  assign res_valid     = valid_q;
  assign res_stale     = stale_q;
  assign res_frame_err = err_q;
endmodule

// File: rtl/serial_adc_rx_chk.sv
module serial_adc_rx_chk #(
  parameter int unsigned CONV_LOW_CYC = 10,
  parameter int unsigned CONV_GAP_CYC = 6250,
  localparam int unsigned LW = $clog2(CONV_LOW_CYC + 2),
  localparam int unsigned GW = $clog2(CONV_GAP_CYC + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic adc_conv_n,
  input logic busy_ok,
  input logic res_valid,
  input logic res_frame_err
);
  logic [LW-1:0] low_run_q;
  logic [GW-1:0] since_fall_q;
  logic          conv_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q    <= '0;
      since_fall_q <= GW'(CONV_GAP_CYC);
      conv_prev_q  <= 1'b1;
    end else begin
      conv_prev_q <= adc_conv_n;
      if (!adc_conv_n) begin
        if (low_run_q != LW'(CONV_LOW_CYC + 1)) low_run_q <= low_run_q + 1'b1;
      end else begin
        low_run_q <= '0;
      end
      if (!adc_conv_n && conv_prev_q) since_fall_q <= GW'(1);
      else if (since_fall_q != GW'(CONV_GAP_CYC)) since_fall_q <= since_fall_q + 1'b1;
    end
  end

  assert_strobe_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv_n) |-> (low_run_q == LW'(CONV_LOW_CYC)));

  assert_strobe_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_n) |-> $past(busy_ok));

  assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv_n) |-> (since_fall_q == GW'(CONV_GAP_CYC)));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_frame_err |=> !res_frame_err);

  assert_valid_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_frame_err));
endmodule

bind serial_adc_rx serial_adc_rx_chk #(
  .CONV_LOW_CYC(CONV_LOW_CYC),
  .CONV_GAP_CYC(CONV_GAP_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_conv_n   (adc_conv_n),
  .busy_ok      (busy_s),
  .res_valid    (res_valid),
  .res_frame_err(res_frame_err)
);

// File: tb/test_serial_adc_rx.sv
module test_serial_adc_rx;
  localparam int unsigned W    = 12;
  localparam int unsigned LOWC = 10;
  localparam int unsigned GAPC = 150;

  logic clk, rst_n, sample_req, adc_dclk, adc_sdata, adc_busy_n;
  logic adc_conv_n, res_valid, res_stale, res_frame_err;
  logic [W-1:0] res_data;

  serial_adc_rx #(
    .DATA_W(W), .SYNC_STAGES(2), .CLK_PERIOD_PS(4000),
    .CONV_LOW_CYC(LOWC), .CONV_GAP_CYC(GAPC)
  ) i_serial_adc_rx (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req),
    .adc_dclk(adc_dclk), .adc_sdata(adc_sdata), .adc_busy_n(adc_busy_n),
    .adc_conv_n(adc_conv_n), .res_data(res_data), .res_valid(res_valid),
    .res_stale(res_stale), .res_frame_err(res_frame_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;
  int n_valid = 0, n_err = 0, n_fall = 0;
  logic [W-1:0] got_word;
  logic got_stale;
  logic conv_prev = 1'b1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (res_valid) begin
      n_valid++;
      got_word  = res_data;
      got_stale = res_stale;
    end
    if (res_frame_err) n_err++;
    if (conv_prev && !adc_conv_n) n_fall++;
    conv_prev = adc_conv_n;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  longint last_fall = -1;
  int frame_idx = 0;

  // Converter model: waits for a strobe, sends nbits of word MSB first, then releases busy.
  task automatic run_frame(input logic [W-1:0] word, input int nbits);
    int v0, e0, f0, width;
    longint fall_at;
    logic [W-1:0] prev_word;
    int exp_val;
    prev_word = got_word;
    v0 = n_valid; e0 = n_err; f0 = n_fall;
    sample_req = 1'b1;
    do @(negedge clk); while (adc_conv_n);
    fall_at = cyc;
    adc_busy_n = 1'b0;
    // R4: request held high, so spacing equals the limit exactly
    if (last_fall >= 0)
      check((fall_at - last_fall) == GAPC, "R4 strobe spacing", fall_at - last_fall, GAPC);
    last_fall = fall_at;
    width = 1;
    forever begin
      @(negedge clk);
      if (adc_conv_n) break;
      width++;
    end
    check(width == LOWC, "R2 strobe width", width, LOWC);
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      adc_sdata = (i < W) ? word[W-1-i] : 1'b0;
      repeat (2) @(negedge clk);
      adc_dclk = 1'b1;
      repeat (4) @(negedge clk);
      adc_dclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    adc_busy_n = 1'b1;
    repeat (10) @(negedge clk);
    // R3: the request stayed high across the frame, yet only one strobe
    check((n_fall - f0) == 1, "R3 one strobe per frame", n_fall - f0, 1);
    if (nbits == W) begin
      check((n_valid - v0) == 1, "R6 valid pulse count", n_valid - v0, 1);
      check((n_err - e0) == 0, "R7 no error on good frame", n_err - e0, 0);
      exp_val = (word >= 12'd2048) ? int'(word) - 4096 : int'(word);
      check($signed(got_word) == exp_val, "R5 received value", $signed(got_word), exp_val);
      check(res_data == word, "R6 data held", res_data, word);
      check(got_stale == (frame_idx == 0), "R8 stale tag", got_stale, (frame_idx == 0));
    end else begin
      check((n_err - e0) == 1, "R7 error pulse count", n_err - e0, 1);
      check((n_valid - v0) == 0, "R7 no valid on bad frame", n_valid - v0, 0);
      check(res_data == prev_word, "R7 data kept", res_data, prev_word);
    end
    frame_idx++;
  endtask

  initial begin
    rst_n = 1'b0; sample_req = 1'b0; adc_dclk = 1'b0; adc_sdata = 1'b0; adc_busy_n = 1'b1;
    got_word = '0; got_stale = 1'b0;
    repeat (3) @(negedge clk);
    check(adc_conv_n == 1'b1, "R1 conv idle in reset", adc_conv_n, 1);
    check(res_valid == 1'b0 && res_frame_err == 1'b0, "R1 pulses low in reset",
          {res_valid, res_frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(adc_conv_n == 1'b1, "R1 conv idle after reset", adc_conv_n, 1);
    check(res_data == '0 && res_stale == 1'b0, "R1 result cleared", res_data, 0);

    // Single-bit positions, sign extremes, then a stride over the code space
    for (int i = 0; i < W; i++) run_frame(12'(1 << i), W);
    run_frame(12'h000, W);
    run_frame(12'hFFF, W);
    run_frame(12'h800, W);
    run_frame(12'h7FF, W);
    for (int k = 0; k < 280; k++) run_frame(12'((k * 37 + 5) % 4096), W);

    // R7: wrong bit counts
    run_frame(12'hA5A, 11);
    run_frame(12'h3C3, 13);
    run_frame(12'h000, 0);
    run_frame(12'h5A5, W);

    // R3: converter holds busy low while a request is pending
    sample_req = 1'b0;
    repeat (GAPC + 5) @(negedge clk);
    begin
      int f0;
      f0 = n_fall;
      adc_busy_n = 1'b0;
      repeat (3) @(negedge clk);
      sample_req = 1'b1;
      repeat (40) @(negedge clk);
      check((n_fall - f0) == 0, "R3 no strobe while busy low", n_fall - f0, 0);
      check(adc_conv_n == 1'b1, "R3 strobe idle while busy low", adc_conv_n, 1);
      sample_req = 1'b0;
      repeat (3) @(negedge clk);
      adc_busy_n = 1'b1;
      repeat (10) @(negedge clk);
      check((n_fall - f0) == 0, "R3 dropped request not replayed", n_fall - f0, 0);
    end

    done = 1;
    report();
  end
endmodule